// File: doc/BRIEF.md
# Keypad Input Port with Press Interrupt

This block is an eight-line, read-only input port on a simple processor I/O bus, intended for key-scan use. Each external line passes through a two-flop synchronizer. When the processor reads the port's address, the synchronized levels come back on the low byte of a 16-bit read bus, and the upper byte is forced to zero.

The block also watches the AND of all eight synchronized lines. A two-state machine tracks that combined level. In state `ST_ARMED` every line was last seen high. The `press` transition (`ST_ARMED` to `ST_HELD`) is taken when any line goes low, and it sets a sticky interrupt-pending flag. The `release` transition (`ST_HELD` to `ST_ARMED`) is taken once all lines are high again. While the machine sits in `ST_HELD`, a further line going low has no effect. The pending flag stays set until the interrupt controller acknowledges it.

A separate one-bit control write sets or clears an enable that switches on the external pullup resistors for all eight lines together. Reset is active-low and asynchronous. It clears the pending flag and the pullup enable, and it returns the machine to `ST_ARMED` with the synchronizers holding all-high.

Top module: `keypad_port`

## Requirements
- R1: A read with `bus_rd`=1 and `bus_addr`=0x28 returns the synchronized pin levels on `rd_data[7:0]`, with line 0 in bit 0 and line 7 in bit 7. A low line reads as 0 and a high line reads as 1.
- R2: Bits 15:8 of `rd_data` are always zero.
- R3: When `bus_rd` is 0, or `bus_addr` is any value other than 0x28, `rd_data` is zero.
- R4: A pin change shows on a port read after exactly two rising clock edges, and not after one.
- R5: `irq_pending` rises only when the AND of the synchronized lines falls from 1 to 0. It becomes visible after the third rising edge following the pin change. All lines returning high raises nothing.
- R6: While any line is held low, another line going low does not set `irq_pending`.
- R7: An `irq_ack` pulse with no coincident press clears `irq_pending` at the next rising edge.
- R8: A press detected on the same edge as `irq_ack` leaves `irq_pending` set.
- R9: `ctl_wr`=1 loads `ctl_din` into `pullup_en`. With `ctl_wr`=0, `pullup_en` holds its value. `pullup_en` is 0 after reset.
- R10: `rst_n`=0 clears `irq_pending` at once, without waiting for a clock edge, and it resets the press history to all-high. A line held low through reset therefore raises `irq_pending` three edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | External key lines |
| bus_addr | input | 8 | I/O bus address |
| bus_rd | input | 1 | I/O read strobe |
| rd_data | output | 16 | Read data, zero-extended |
| ctl_wr | input | 1 | Pullup control write strobe |
| ctl_din | input | 1 | Pullup control write value |
| pullup_en | output | 1 | Enable for all eight pullups |
| irq_ack | input | 1 | Clears the pending interrupt |
| irq_pending | output | 1 | Sticky press interrupt request |

## Verification
A corrupted press state shows at the ports within three edges of the next pin change. If the machine is wrongly left in `ST_HELD`, a fresh press from all-high raises no request. If it is wrongly left in `ST_ARMED`, a second key pressed while the first is held raises a spurious one. A wrong synchronizer depth shifts the read value and the request by one edge, so the bench samples reads one and two edges after a change. The ack/press collision and a line held low through reset are driven directly, because both outcomes depend on the exact cycle.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

    // Press tracker: ARMED = all lines last seen high, HELD = some line low
    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_HELD  = 1'b1
    } kp_state_e;

    localparam int KP_MIN_SYNC = 2;

endpackage

// File: rtl/keypad_sync.sv
module keypad_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // Each bit gets its own flop chain, reset to the idle (high) level
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{1'b1}};
            end else begin
                chain <= {chain[STAGES-2:0], din[b]};
            end
        end

        assign dout[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/keypad_edge_fsm.sv
module keypad_edge_fsm
    import keypad_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      all_high,
    output logic      press,
    output kp_state_e state
);
    kp_state_e state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ARMED;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and output
    always_comb begin
        state_nx = state;
        press    = 1'b0;
        unique case (state)
            ST_ARMED: begin
                if (!all_high) begin
                    state_nx = ST_HELD;   // press transition
                    press    = 1'b1;
                end
            end
            ST_HELD: begin
                if (all_high) begin
                    state_nx = ST_ARMED;  // release transition
                end
            end
        endcase
    end
endmodule

// File: rtl/keypad_irq.sv
module keypad_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic press,
    input  logic ack,
    output logic pending
);
    // A press takes priority over an acknowledge on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (press) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/keypad_port.sv
module keypad_port
    import keypad_pkg::*;
#(
    parameter int              PIN_W       = 8,
    parameter int              DATA_W      = 16,
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h28,
    parameter int              SYNC_STAGES = KP_MIN_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pin_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ctl_wr,
    input  logic              ctl_din,
    output logic              pullup_en,
    input  logic              irq_ack,
    output logic              irq_pending
);
    localparam int PAD_W = DATA_W - PIN_W;

    logic [PIN_W-1:0] sync_q;
    logic             all_high;
    logic             press;
    kp_state_e        state;
    logic             port_sel;

    keypad_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_i),
        .dout  (sync_q)
    );

    assign all_high = &sync_q;

    keypad_edge_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .all_high (all_high),
        .press    (press),
        .state    (state)
    );

    keypad_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .press   (press),
        .ack     (irq_ack),
        .pending (irq_pending)
    );

    // Pullup enable control bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pullup_en <= 1'b0;
        end else if (ctl_wr) begin
            pullup_en <= ctl_din;
        end
    end

    // Read path, zero-extended
    assign port_sel = bus_rd && (bus_addr == PORT_ADDR);
    assign rd_data  = port_sel ? {{PAD_W{1'b0}}, sync_q} : '0;
endmodule

// File: rtl/keypad_port_chk.sv
module keypad_port_chk
    import keypad_pkg::*;
#(
    parameter int                PIN_W     = 8,
    parameter int                DATA_W    = 16,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h28
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] rd_data,
    input logic              ctl_wr,
    input logic              ctl_din,
    input logic              pullup_en,
    input logic              irq_ack,
    input logic              irq_pending,
    input logic [PIN_W-1:0]  sync_q,
    input logic              press
);
    assert_read_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == PORT_ADDR) |-> rd_data[PIN_W-1:0] == sync_q);

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:PIN_W] == '0);

    assert_idle_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == PORT_ADDR) |-> rd_data == '0);

    assert_press_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> irq_pending);

    assert_rise_from_press_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> $past(press));

    assert_no_fire_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        press |-> $past(&sync_q));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !press) |=> !irq_pending);

    assert_pullup_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> pullup_en == $past(ctl_din));

    assert_pullup_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(pullup_en));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_state_R10: assert (!irq_pending && !pullup_en);
        end
    end
endmodule

bind keypad_port keypad_port_chk #(
    .PIN_W(PIN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .rd_data(rd_data), .ctl_wr(ctl_wr), .ctl_din(ctl_din),
    .pullup_en(pullup_en), .irq_ack(irq_ack), .irq_pending(irq_pending),
    .sync_q(sync_q), .press(press)
);

// File: tb/keypad_port_bench.sv
module keypad_port_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [7:0]  pin_i = 8'hFF;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_rd = 1'b0;
    logic [15:0] rd_data;
    logic        ctl_wr = 1'b0;
    logic        ctl_din = 1'b0;
    logic        pullup_en;
    logic        irq_ack = 1'b0;
    logic        irq_pending;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t scb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    keypad_port u_keypad_port (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .rd_data(rd_data), .ctl_wr(ctl_wr),
        .ctl_din(ctl_din), .pullup_en(pullup_en), .irq_ack(irq_ack),
        .irq_pending(irq_pending)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: queue the expected value, then strobe a read for one cycle
    task automatic do_read(input logic [7:0] addr, input logic [15:0] exp,
                           input string tag);
        rd_item_t it;
        @(negedge clk);
        #1;
        it.exp = exp;
        it.tag = tag;
        scb_q.push_back(it);
        bus_addr = addr;
        bus_rd   = 1'b1;
        @(negedge clk);
        #1 bus_rd = 1'b0;
    endtask

    // Monitor: compare each read cycle with the head of the queue
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            if (scb_q.size() == 0) begin
                chk(1'b0, "SCB", rd_data, 16'h0);
            end else begin
                rd_item_t it;
                it = scb_q.pop_front();
                chk(rd_data == it.exp, it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        wait_n(3);
        chk(irq_pending == 1'b0, "R10 reset pending", {15'h0, irq_pending}, 16'h0);
        chk(pullup_en == 1'b0, "R9 reset pullup", {15'h0, pullup_en}, 16'h0);
        #1 rst_n = 1'b1;

        do_read(8'h28, 16'h00FF, "R1 idle all high");

        // R4: read held across a pin change, one then two edges later
        @(negedge clk);
        #1;
        pin_i = 8'hFE; bus_addr = 8'h28; bus_rd = 1'b1;
        scb_q.push_back('{16'h00FF, "R4 one edge still old"});
        scb_q.push_back('{16'h00FE, "R4 two edges new"});
        wait_n(2);
        chk(irq_pending == 1'b0, "R5 not before third edge", {15'h0, irq_pending}, 16'h0);
        #1 bus_rd = 1'b0;
        wait_n(1);
        chk(irq_pending == 1'b1, "R5 press sets pending", {15'h0, irq_pending}, 16'h1);

        // R7 acknowledge
        #1 irq_ack = 1'b1;
        wait_n(1);
        chk(irq_pending == 1'b0, "R7 ack clears", {15'h0, irq_pending}, 16'h0);
        #1 irq_ack = 1'b0;

        // R6 second key while first held
        pin_i = 8'hFC;
        wait_n(5);
        chk(irq_pending == 1'b0, "R6 second key ignored", {15'h0, irq_pending}, 16'h0);
        do_read(8'h28, 16'h00FC, "R1 two keys low");

        // release raises nothing
        pin_i = 8'hFF;
        wait_n(4);
        chk(irq_pending == 1'b0, "R5 release no request", {15'h0, irq_pending}, 16'h0);

        // new pattern press
        pin_i = 8'h5A;
        wait_n(3);
        chk(irq_pending == 1'b1, "R5 pattern 5A press", {15'h0, irq_pending}, 16'h1);
        do_read(8'h28, 16'h005A, "R1 R2 pattern 5A");
        do_read(8'h27, 16'h0000, "R3 other address");
        do_read(8'h29, 16'h0000, "R3 other address");
        chk(rd_data == 16'h0, "R3 no read strobe", rd_data, 16'h0);

        // R8 ack colliding with a press
        #1 pin_i = 8'hFF;
        wait_n(4);
        #1 pin_i = 8'h7F;
        wait_n(2);
        #1 irq_ack = 1'b1;
        wait_n(1);
        chk(irq_pending == 1'b1, "R8 press wins over ack", {15'h0, irq_pending}, 16'h1);
        #1 irq_ack = 1'b0;
        wait_n(1);
        chk(irq_pending == 1'b1, "R8 still pending", {15'h0, irq_pending}, 16'h1);
        #1 irq_ack = 1'b1;
        wait_n(1);
        chk(irq_pending == 1'b0, "R7 later ack clears", {15'h0, irq_pending}, 16'h0);
        #1 irq_ack = 1'b0;

        // R9 pullup control
        ctl_wr = 1'b1; ctl_din = 1'b1;
        wait_n(1);
        chk(pullup_en == 1'b1, "R9 write one", {15'h0, pullup_en}, 16'h1);
        #1 ctl_wr = 1'b0; ctl_din = 1'b0;
        wait_n(2);
        chk(pullup_en == 1'b1, "R9 hold without strobe", {15'h0, pullup_en}, 16'h1);
        #1 ctl_wr = 1'b1; ctl_din = 1'b0;
        wait_n(1);
        chk(pullup_en == 1'b0, "R9 write zero", {15'h0, pullup_en}, 16'h0);
        #1 ctl_wr = 1'b0;

        // R10 asynchronous reset and all-high history
        pin_i = 8'hFF;
        wait_n(4);
        #1 pin_i = 8'hFE;
        ctl_wr = 1'b1; ctl_din = 1'b1;
        wait_n(3);
        chk(irq_pending == 1'b1, "R10 pending before reset", {15'h0, irq_pending}, 16'h1);
        #1 ctl_wr = 1'b0;
        #1 rst_n = 1'b0;
        #1;
        chk(irq_pending == 1'b0, "R10 async clear", {15'h0, irq_pending}, 16'h0);
        chk(pullup_en == 1'b0, "R9 R10 reset clears pullup", {15'h0, pullup_en}, 16'h0);
        wait_n(1);
        #1 rst_n = 1'b1;
        wait_n(2);
        chk(irq_pending == 1'b0, "R10 no request yet", {15'h0, irq_pending}, 16'h0);
        wait_n(1);
        chk(irq_pending == 1'b1, "R10 held line fires after reset", {15'h0, irq_pending}, 16'h1);

        wait_n(2);
        chk(scb_q.size() == 0, "SCB drained", 16'(scb_q.size()), 16'h0);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule